// File: doc/BRIEF.md
# Serial Flash Status Register File

This block holds the three 8-bit status registers of a serial NOR flash device model. It sits behind an SPI front end that has already done the bit shifting. The front end hands the block three kinds of event: an opcode strobe carrying the command byte, a data-byte strobe for each byte that follows in the same chip-select frame, and a frame-end pulse when chip select is released.

The block does several jobs from those events:
- It selects which register is presented on the read byte.
- It keeps the write-enable latch and a one-shot volatile-write enable.
- It follows a busy flag raised and dropped by the program/erase engine.
- It applies a status write command that fills the first, second and third registers from consecutive data bytes.

Per-bit write masks keep read-only and reserved bits untouched. The security lock bits can only be set, never cleared. All three registers are also driven out in full, so that the protection decoder next to this block can use them.

Top module: `flash_status_regfile`

## Requirements
- R1: Opcode 8'h05 selects the first register, 8'h35 the second and 8'h33 the third for `rd_byte`, from the cycle after the opcode strobe. Other opcodes leave the selection unchanged. After reset the first register is selected.
- R2: Opcode 8'h06 sets the write-enable latch, shown on `sr1_o[1]`. Opcode 8'h04 clears the write-enable latch and the volatile-write enable.
- R3: `busy_set` sets the busy flag on `sr1_o[0]` and `busy_clr` clears it. If both are high, set wins. The result shows one cycle later.
- R4: After opcode 8'h01, the 1st, 2nd and 3rd data bytes of the frame load the first, second and third register, each in the cycle after its strobe. Data bytes beyond the third are ignored.
- R5: In the first register only bits 7..2 take the written value. Bits 1..0 always show the write-enable latch and busy.
- R6: In the second and third registers bits 6..0 take the written value. Bit 7 always reads 0.
- R7: The lock bits, bits 5..2 of the second register, cannot be cleared by a write once they are 1.
- R8: A status write is accepted only if the write-enable latch or the volatile-write enable is set when opcode 8'h01 arrives. Opcode 8'h50 sets the volatile-write enable, and the next 8'h01 opcode consumes it whether or not that write is accepted.
- R9: An accepted status write clears the write-enable latch in the cycle after `frame_end`. A rejected write leaves the latch as it was.
- R10: A frame that ends after one or two data bytes updates only the registers whose bytes arrived.
- R11: A status write is rejected when busy is 1 at the 8'h01 opcode.
- R12: After reset all three registers read 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode strobe, one cycle |
| op_code | input | 8 | Command byte, valid with `op_valid` |
| dat_valid | input | 1 | Data-byte strobe, one cycle per byte |
| dat_byte | input | 8 | Data byte, valid with `dat_valid` |
| frame_end | input | 1 | Chip-select release pulse |
| busy_set | input | 1 | Program/erase engine started |
| busy_clr | input | 1 | Program/erase engine finished |
| sr1_o | output | 8 | First status register |
| sr2_o | output | 8 | Second status register |
| sr3_o | output | 8 | Third status register |
| rd_byte | output | 8 | Register chosen by the last read opcode |

## Verification
Every result of this block is due exactly one clock after the edge that samples its strobe:
- the read selection after a read opcode;
- the latch after 8'h06 or 8'h04;
- a register after its data byte;
- the latch clear after `frame_end`;
- busy after `busy_set` or `busy_clr`.

The bench drives each strobe at a falling edge and holds it for one period. It then compares all four outputs at the next falling edge, which is after the single register stage and away from the active edge. A reference model in the bench is updated at the same step, covering directed corner cases and a seeded random mix of commands, frame lengths and busy pulses.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

   localparam int SR_W   = 8;
   localparam int SR_CNT = 3;

   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RD1   = 8'h05;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_RD3   = 8'h33;
   localparam logic [7:0] OP_RD2   = 8'h35;
   localparam logic [7:0] OP_VWREN = 8'h50;

   typedef struct packed {
      logic rd1;
      logic rd2;
      logic rd3;
      logic wren;
      logic wrdi;
      logic vwren;
      logic wrsr;
   } sr_evt_t;

   // writable bits of each register
   function automatic logic [SR_W-1:0] sr_wmask(input int idx);
      case (idx)
         0:       return 8'hFC;
         default: return 8'h7F;
      endcase
   endfunction

   // bits that can only be set by a write (lock bits)
   function automatic logic [SR_W-1:0] sr_sticky(input int idx);
      return (idx == 1) ? 8'h3C : 8'h00;
   endfunction

endpackage

// File: rtl/sr_cmd_decode.sv
module sr_cmd_decode
   import flash_sr_pkg::*;
(
   input  logic       op_valid,
   input  logic [7:0] op_code,
   output sr_evt_t    evt
);

   always_comb begin
      evt       = '0;
      if (op_valid) begin
         evt.rd1   = (op_code == OP_RD1);
         evt.rd2   = (op_code == OP_RD2);
         evt.rd3   = (op_code == OP_RD3);
         evt.wren  = (op_code == OP_WREN);
         evt.wrdi  = (op_code == OP_WRDI);
         evt.vwren = (op_code == OP_VWREN);
         evt.wrsr  = (op_code == OP_WRSR);
      end
   end

endmodule

// File: rtl/sr_write_seq.sv
module sr_write_seq #(
   parameter int NREG = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            permit,
   input  logic            dat_valid,
   input  logic            frame_end,
   output logic [NREG-1:0] reg_we,
   output logic            wr_done
);

   localparam int IW = $clog2(NREG + 1);

   logic          active_q;
   logic          ok_q;
   logic [IW-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ok_q     <= 1'b0;
         idx_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         ok_q     <= permit;
         idx_q    <= '0;
      end else if (frame_end) begin
         active_q <= 1'b0;
         ok_q     <= 1'b0;
      end else if (dat_valid && active_q && (idx_q < IW'(NREG))) begin
         idx_q    <= idx_q + 1'b1;
      end
   end

   for (genvar i = 0; i < NREG; i++) begin : g_we
      assign reg_we[i] = dat_valid && active_q && ok_q && (idx_q == IW'(i));
   end

   assign wr_done = frame_end && active_q && ok_q;

   // R4: one register per data byte at most
   assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_we));

   // R4: each register accepts at most once per frame, in order
   assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we != '0) |=> !(reg_we & $past(reg_we)));

endmodule

// File: rtl/sr_reg.sv
module sr_reg #(
   parameter int         W      = 8,
   parameter logic [W-1:0] WMASK  = '1,
   parameter logic [W-1:0] STICKY = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);

   if (STICKY == '0) begin : g_plain
      always_ff @(posedge clk) begin
         if (!rst_n)  q <= '0;
         else if (we) q <= (q & ~WMASK) | (din & WMASK);
      end
   end else begin : g_sticky
      always_ff @(posedge clk) begin
         if (!rst_n)  q <= '0;
         else if (we) q <= (q & ~WMASK) | (din & WMASK) | (q & STICKY);
      end

      // R7: once a lock bit is 1 it stays 1
      assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ((q & STICKY) != '0) |=> ((q & $past(q & STICKY)) == $past(q & STICKY)));
   end

   // R5: without a write strobe the register holds
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/flash_status_regfile.sv
module flash_status_regfile
   import flash_sr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_valid,
   input  logic [7:0] op_code,
   input  logic       dat_valid,
   input  logic [7:0] dat_byte,
   input  logic       frame_end,
   input  logic       busy_set,
   input  logic       busy_clr,
   output logic [7:0] sr1_o,
   output logic [7:0] sr2_o,
   output logic [7:0] sr3_o,
   output logic [7:0] rd_byte
);

   sr_evt_t                    evt;
   logic                       wel_q, vol_q, busy_q;
   logic [1:0]                 sel_q;
   logic [SR_CNT-1:0]          reg_we;
   logic                       wr_done;
   logic [SR_CNT-1:0][SR_W-1:0] store;

   sr_cmd_decode u_dec (
      .op_valid (op_valid),
      .op_code  (op_code),
      .evt      (evt)
   );

   sr_write_seq #(.NREG(SR_CNT)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (evt.wrsr),
      .permit    ((wel_q || vol_q) && !busy_q),
      .dat_valid (dat_valid),
      .frame_end (frame_end),
      .reg_we    (reg_we),
      .wr_done   (wr_done)
   );

   for (genvar i = 0; i < SR_CNT; i++) begin : g_reg
      sr_reg #(
         .W      (SR_W),
         .WMASK  (sr_wmask(i)),
         .STICKY (sr_sticky(i))
      ) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (reg_we[i]),
         .din   (dat_byte),
         .q     (store[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wel_q  <= 1'b0;
         vol_q  <= 1'b0;
         busy_q <= 1'b0;
         sel_q  <= 2'd0;
      end else begin
         if (wr_done)   wel_q <= 1'b0;
         if (evt.wren)  wel_q <= 1'b1;
         if (evt.wrdi)  wel_q <= 1'b0;

         if (evt.vwren)                vol_q <= 1'b1;
         if (evt.wrsr || evt.wrdi)     vol_q <= 1'b0;

         if (busy_set)      busy_q <= 1'b1;
         else if (busy_clr) busy_q <= 1'b0;

         if (evt.rd1) sel_q <= 2'd0;
         if (evt.rd2) sel_q <= 2'd1;
         if (evt.rd3) sel_q <= 2'd2;
      end
   end

   assign sr1_o = (store[0] & sr_wmask(0)) | {6'b0, wel_q, busy_q};
   assign sr2_o = store[1];
   assign sr3_o = store[2];

   always_comb begin
      case (sel_q)
         2'd1:    rd_byte = sr2_o;
         2'd2:    rd_byte = sr3_o;
         default: rd_byte = sr1_o;
      endcase
   end

   assert_wren_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_WREN) |=> sr1_o[1]);

   assert_wrdi_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_WRDI) |=> !sr1_o[1]);

   assert_busy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_set |=> sr1_o[0]);

   assert_busy_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_clr && !busy_set) |=> !sr1_o[0]);

   assert_read_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_RD2) |=> (rd_byte == sr2_o));

   assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we[2] |=> (sr3_o[7] == 1'b0));

endmodule

// File: tb/sim_flash_status_regfile.sv
module sim_flash_status_regfile;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [7:0] op_code = 8'h00;
   logic       dat_valid = 1'b0;
   logic [7:0] dat_byte = 8'h00;
   logic       frame_end = 1'b0;
   logic       busy_set = 1'b0;
   logic       busy_clr = 1'b0;
   logic [7:0] sr1_o, sr2_o, sr3_o, rd_byte;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model state
   logic [7:0] m1 = 8'h00, m2 = 8'h00, m3 = 8'h00;
   logic       m_wel = 1'b0, m_vol = 1'b0, m_busy = 1'b0;
   int         m_sel = 0;

   always #2.5 clk = ~clk;

   flash_status_regfile u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .dat_valid(dat_valid), .dat_byte(dat_byte), .frame_end(frame_end),
      .busy_set(busy_set), .busy_clr(busy_clr),
      .sr1_o(sr1_o), .sr2_o(sr2_o), .sr3_o(sr3_o), .rd_byte(rd_byte)
   );

   function automatic logic [7:0] next_val(input int idx, input logic [7:0] old,
                                           input logic [7:0] d);
      case (idx)
         0:       return d & 8'hFC;
         1:       return (d & 8'h7F) | (old & 8'h3C);
         default: return d & 8'h7F;
      endcase
   endfunction

   function automatic logic [7:0] exp_sr1();
      return {m1[7:2], m_wel, m_busy};
   endfunction

   function automatic logic [7:0] exp_rd();
      case (m_sel)
         1:       return m2;
         2:       return m3;
         default: return exp_sr1();
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check(req, "sr1", sr1_o, exp_sr1());
      check(req, "sr2", sr2_o, m2);
      check(req, "sr3", sr3_o, m3);
      check(req, "rd_byte", rd_byte, exp_rd());
   endtask

   task automatic send_op(input logic [7:0] c);
      @(negedge clk);
      op_valid = 1'b1;
      op_code  = c;
      @(negedge clk);
      op_valid = 1'b0;
      case (c)
         8'h05: m_sel = 0;
         8'h35: m_sel = 1;
         8'h33: m_sel = 2;
         8'h06: m_wel = 1'b1;
         8'h04: begin m_wel = 1'b0; m_vol = 1'b0; end
         8'h50: m_vol = 1'b1;
         default: ;
      endcase
   endtask

   task automatic busy_pulse(input bit s, input bit c);
      @(negedge clk);
      busy_set = s;
      busy_clr = c;
      @(negedge clk);
      busy_set = 1'b0;
      busy_clr = 1'b0;
      if (s) m_busy = 1'b1;
      else if (c) m_busy = 1'b0;
   endtask

   task automatic wr_frame(input int n, input logic [31:0] bytes);
      logic ok;
      ok = (m_wel || m_vol) && !m_busy;
      send_op(8'h01);
      m_vol = 1'b0;
      for (int k = 0; k < n; k++) begin
         logic [7:0] b;
         b = bytes[8*(k%4) +: 8];
         @(negedge clk);
         dat_valid = 1'b1;
         dat_byte  = b;
         @(negedge clk);
         dat_valid = 1'b0;
         if (ok) begin
            if (k == 0) m1 = next_val(0, m1, b);
            if (k == 1) m2 = next_val(1, m2, b);
            if (k == 2) m3 = next_val(2, m3, b);
         end
      end
      @(negedge clk);
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
      if (ok) m_wel = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R12");

      // R8: no enable, write ignored
      wr_frame(3, 32'h00FFFFFF);
      check_all("R8");

      // R2: latch set and clear
      send_op(8'h06);
      check("R2", "wel set", sr1_o, 8'h02);
      send_op(8'h04);
      check("R2", "wel clr", sr1_o, 8'h00);
      send_op(8'h06);

      // R4 R5 R6 R9: full write of ones
      wr_frame(3, 32'h00FFFFFF);
      check("R5", "sr1 mask", sr1_o, 8'hFC);
      check("R6", "sr2 mask", sr2_o, 8'h7F);
      check("R6", "sr3 mask", sr3_o, 8'h7F);
      check("R9", "wel after write", {7'b0, sr1_o[1]}, 8'h00);

      // R1: read selection
      send_op(8'h35);
      check("R1", "rd sr2", rd_byte, 8'h7F);
      send_op(8'h9F);
      check("R1", "other opcode keeps sel", rd_byte, 8'h7F);
      send_op(8'h33);
      check("R1", "rd sr3", rd_byte, m3);
      send_op(8'h05);
      check("R1", "rd sr1", rd_byte, 8'hFC);

      // R7: locks stay set
      send_op(8'h06);
      wr_frame(3, 32'h00000000);
      check("R7", "locks kept", sr2_o, 8'h3C);
      check_all("R7");

      // R8 R10: volatile enable, one byte only
      send_op(8'h50);
      wr_frame(1, 32'h000000A9);
      check("R10", "sr1 only", sr1_o, 8'hA8);
      check("R10", "sr2 untouched", sr2_o, 8'h3C);
      wr_frame(1, 32'h00000000);
      check("R8", "vol consumed", sr1_o, 8'hA8);

      // R11 R3: rejected while busy
      busy_pulse(1'b1, 1'b0);
      check("R3", "busy set", {7'b0, sr1_o[0]}, 8'h01);
      send_op(8'h06);
      wr_frame(3, 32'h00123456);
      check("R11", "busy reject sr1", sr1_o, 8'hAB);
      check("R9", "wel kept after reject", {7'b0, sr1_o[1]}, 8'h01);
      busy_pulse(1'b1, 1'b1);
      check("R3", "set wins", {7'b0, sr1_o[0]}, 8'h01);
      busy_pulse(1'b0, 1'b1);
      check("R3", "busy clr", {7'b0, sr1_o[0]}, 8'h00);

      // R4: extra bytes ignored
      wr_frame(5, 32'h44332211);
      check_all("R4");
      check("R4", "sr3 third byte", sr3_o, 8'h33);

      // R10: two bytes only
      send_op(8'h06);
      wr_frame(2, 32'h00FF5580);
      check("R10", "sr3 untouched", sr3_o, 8'h33);
      check_all("R10");

      // random mix
      void'($urandom(32'd20240611));
      for (int it = 0; it < 400; it++) begin
         int r;
         r = $urandom_range(0, 9);
         case (r)
            0: send_op(8'h05);
            1: send_op(8'h35);
            2: send_op(8'h33);
            3, 4: send_op(8'h06);
            5: send_op(8'h04);
            6: send_op(8'h50);
            7: busy_pulse(1'($urandom_range(0, 3) == 0), 1'b1);
            default: wr_frame($urandom_range(0, 4), $urandom);
         endcase
         check_all("R1/R2/R4/R7/R8");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule